// File: doc/BRIEF.md
# Byte-Lane Registered Bidirectional Transceiver

This block connects two 32-bit ports, A and B, through four independent 8-bit lanes. Each lane holds one register that samples the A bus and one that samples the B bus. It can drive either port from the other port's live value or from the stored register. The lane controls are separate: two load strobes, two source selects and two enables. Tying the same control bit across all lanes gives full-width operation. Each port is modelled as an input vector, an output vector and a per-lane output-enable. The bus value the lane sees is its own output when it drives the port and the input vector otherwise.

Load strobes are ordinary inputs sampled by the block clock. A low-to-high change seen on a strobe loads that side's register from the current bus value, whatever the selects and enables are. When both ports are enabled and both selects choose live data, the lane becomes a bus keeper. Each port then goes on presenting the value its bus carried at the last clock edge before keeper mode began.

Top module: `bus_xcvr_bank`

## Requirements
- R1: After reset every A register, B register and keeper value is zero. With both ports enabled and both selects set to stored, every lane drives 0x00 on both ports.
- R2: Per lane, `b_oe` equals `drive_b` (active high) and `a_oe` equals the inverse of `drive_a_n` (active low). Both ports are inputs (isolation) when `drive_b`=0 and `drive_a_n`=1.
- R3: A clock edge at which `a_load` is 1 and was 0 at the previous edge loads the lane's A register from the A bus. Enables and selects do not affect this. At any other edge the register keeps its value, including while `a_load` stays high.
- R4: The same rule loads the B register from the B bus on a rising `b_load`.
- R5: With `a2b_stored`=0 and the lane not in keeper mode, `b_out` equals the A bus: `a_in` when A is not driven, otherwise `a_out`.
- R6: With `a2b_stored`=1, `b_out` equals the lane's A register.
- R7: With `b2a_stored`=0 and the lane not in keeper mode, `a_out` equals the B bus: `b_in` when B is not driven, otherwise `b_out`.
- R8: With `b2a_stored`=1, `a_out` equals the lane's B register.
- R9: While a port is driven, loading its register captures the driven value. Driving A from live B and pulsing both loads copies B data into both registers.
- R10: Keeper mode is `drive_b`=1, `drive_a_n`=0, `a2b_stored`=0, `b2a_stored`=0. In it, `a_out` and `b_out` hold the A and B bus values from the last clock edge before the mode was entered. They stay fixed whatever `a_in` and `b_in` do.
- R11: Lane k (bits 8k+7..8k) depends only on control bit k. Activity in one lane leaves the outputs, enables and registers of every other lane unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples load strobes and updates all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 32 | Value driven onto the A port by other devices |
| a_out | output | 32 | Value this block drives onto the A port |
| a_oe | output | 4 | Per-lane A port drive enable |
| b_in | input | 32 | Value driven onto the B port by other devices |
| b_out | output | 32 | Value this block drives onto the B port |
| b_oe | output | 4 | Per-lane B port drive enable |
| a_load | input | 4 | Per-lane A register load strobe (rising change) |
| b_load | input | 4 | Per-lane B register load strobe (rising change) |
| a2b_stored | input | 4 | Per-lane B port source: 0 live A bus, 1 A register |
| b2a_stored | input | 4 | Per-lane A port source: 0 live B bus, 1 B register |
| drive_b | input | 4 | Per-lane B port enable, active high |
| drive_a_n | input | 4 | Per-lane A port enable, active low |

## Verification
The hardest cases are the ones where a register loads from a port the lane is driving itself. The loaded value then comes from the lane's own output path and not from `a_in` or `b_in`. The bench reaches these cases with table rows that drive the opposite port while the `a_in`/`b_in` values are deliberately wrong. The rows then read both registers back through the stored selects. Keeper mode is entered without a clock edge, straight from isolation, so the held values are known exactly. The bus inputs are then changed across several edges.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    DIR_NONE = 2'b00,
    DIR_TO_B = 2'b01,
    DIR_TO_A = 2'b10,
    DIR_BOTH = 2'b11
  } lane_dir_e;

  // B enable is active high, A enable is active low.
  function automatic lane_dir_e dir_decode(input logic en_b, input logic en_a_n);
    case ({~en_a_n, en_b})
      2'b01:   return DIR_TO_B;
      2'b10:   return DIR_TO_A;
      2'b11:   return DIR_BOTH;
      default: return DIR_NONE;
    endcase
  endfunction

endpackage

// File: rtl/rise_detect.sv
module rise_detect #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] level,
  output logic [N-1:0] rise
);

  logic [N-1:0] prev_q;
  logic [N-1:0] prev_d;

  always_comb begin
    prev_d = level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  assign rise = level & ~prev_q;

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_a,
  input  logic         ld_b,
  input  logic         sel_a2b,
  input  logic         sel_b2a,
  input  logic         en_b,
  input  logic         en_a_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out,
  output logic         a_oe,
  output logic         b_oe
);

  lane_dir_e    dir;
  logic         keep;
  logic [W-1:0] ra_q, ra_d;
  logic [W-1:0] rb_q, rb_d;
  logic [W-1:0] ha_q, ha_d;
  logic [W-1:0] hb_q, hb_d;
  logic [W-1:0] a_bus, b_bus;

  always_comb begin
    dir  = dir_decode(en_b, en_a_n);
    a_oe = (dir == DIR_TO_A) || (dir == DIR_BOTH);
    b_oe = (dir == DIR_TO_B) || (dir == DIR_BOTH);
    keep = (dir == DIR_BOTH) && !sel_a2b && !sel_b2a;
  end

  // Output sources resolved case by case so no structural loop exists.
  always_comb begin
    if (keep)                  a_out = ha_q;
    else if (sel_b2a)          a_out = rb_q;
    else if (b_oe && sel_a2b)  a_out = ra_q;
    else                       a_out = b_in;

    if (keep)                  b_out = hb_q;
    else if (sel_a2b)          b_out = ra_q;
    else if (a_oe && sel_b2a)  b_out = rb_q;
    else                       b_out = a_in;
  end

  always_comb begin
    a_bus = a_oe ? a_out : a_in;
    b_bus = b_oe ? b_out : b_in;
  end

  always_comb begin
    ra_d = ld_a ? a_bus : ra_q;
    rb_d = ld_b ? b_bus : rb_q;
    ha_d = keep ? ha_q  : a_bus;
    hb_d = keep ? hb_q  : b_bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra_q <= '0;
      rb_q <= '0;
      ha_q <= '0;
      hb_q <= '0;
    end else begin
      ra_q <= ra_d;
      rb_q <= rb_d;
      ha_q <= ha_d;
      hb_q <= hb_d;
    end
  end

endmodule

// File: rtl/bus_xcvr_bank.sv
module bus_xcvr_bank #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*LANE_W-1:0] a_in,
  output logic [LANES*LANE_W-1:0] a_out,
  output logic [LANES-1:0]        a_oe,
  input  logic [LANES*LANE_W-1:0] b_in,
  output logic [LANES*LANE_W-1:0] b_out,
  output logic [LANES-1:0]        b_oe,
  input  logic [LANES-1:0]        a_load,
  input  logic [LANES-1:0]        b_load,
  input  logic [LANES-1:0]        a2b_stored,
  input  logic [LANES-1:0]        b2a_stored,
  input  logic [LANES-1:0]        drive_b,
  input  logic [LANES-1:0]        drive_a_n
);

  localparam int BUS_W = LANES * LANE_W;

  logic [LANES-1:0] ld_a_rise;
  logic [LANES-1:0] ld_b_rise;

  rise_detect #(.N(LANES)) u_rise_a (
    .clk   (clk),
    .rst_n (rst_n),
    .level (a_load),
    .rise  (ld_a_rise)
  );

  rise_detect #(.N(LANES)) u_rise_b (
    .clk   (clk),
    .rst_n (rst_n),
    .level (b_load),
    .rise  (ld_b_rise)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    xcvr_lane #(.W(LANE_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_a    (ld_a_rise[g]),
      .ld_b    (ld_b_rise[g]),
      .sel_a2b (a2b_stored[g]),
      .sel_b2a (b2a_stored[g]),
      .en_b    (drive_b[g]),
      .en_a_n  (drive_a_n[g]),
      .a_in    (a_in[g*LANE_W +: LANE_W]),
      .b_in    (b_in[g*LANE_W +: LANE_W]),
      .a_out   (a_out[g*LANE_W +: LANE_W]),
      .b_out   (b_out[g*LANE_W +: LANE_W]),
      .a_oe    (a_oe[g]),
      .b_oe    (b_oe[g])
    );
  end

  if (BUS_W != LANES * LANE_W) begin : g_bad_width
    $error("bus width mismatch");
  end

endmodule

// File: rtl/bus_xcvr_bank_chk.sv
module bus_xcvr_bank_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [LANES*LANE_W-1:0] a_in,
  input logic [LANES*LANE_W-1:0] a_out,
  input logic [LANES-1:0]        a_oe,
  input logic [LANES*LANE_W-1:0] b_in,
  input logic [LANES*LANE_W-1:0] b_out,
  input logic [LANES-1:0]        b_oe,
  input logic [LANES-1:0]        a_load,
  input logic [LANES-1:0]        b_load,
  input logic [LANES-1:0]        a2b_stored,
  input logic [LANES-1:0]        b2a_stored,
  input logic [LANES-1:0]        drive_b,
  input logic [LANES-1:0]        drive_a_n
);

  logic [LANES-1:0] la_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) la_seen_q <= '0;
    else        la_seen_q <= a_load;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    // R2: enable polarity per lane
    assert_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (a_oe[i] == !drive_a_n[i]) && (b_oe[i] == drive_b[i]));

    // R3 and R6: stored A value stays put without a rising load
    assert_a_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_b[i] && a2b_stored[i] && !(a_load[i] && !la_seen_q[i]))
      |=> (!(drive_b[i] && a2b_stored[i]) || $stable(b_out[i*LANE_W +: LANE_W])));

    // R5: live A to B when A is not driven
    assert_live_a2b_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_b[i] && !a2b_stored[i] && drive_a_n[i])
      |-> (b_out[i*LANE_W +: LANE_W] == a_in[i*LANE_W +: LANE_W]));

    // R7: live B to A when B is not driven
    assert_live_b2a_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!drive_a_n[i] && !b2a_stored[i] && !drive_b[i])
      |-> (a_out[i*LANE_W +: LANE_W] == b_in[i*LANE_W +: LANE_W]));

    // R10: keeper holds both ports steady
    assert_keeper_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_b[i] && !drive_a_n[i] && !a2b_stored[i] && !b2a_stored[i]) &&
      $past(drive_b[i] && !drive_a_n[i] && !a2b_stored[i] && !b2a_stored[i])
      |-> ($stable(a_out[i*LANE_W +: LANE_W]) && $stable(b_out[i*LANE_W +: LANE_W])));
  end

endmodule

bind bus_xcvr_bank bus_xcvr_bank_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .a_in       (a_in),
  .a_out      (a_out),
  .a_oe       (a_oe),
  .b_in       (b_in),
  .b_out      (b_out),
  .b_oe       (b_oe),
  .a_load     (a_load),
  .b_load     (b_load),
  .a2b_stored (a2b_stored),
  .b2a_stored (b2a_stored),
  .drive_b    (drive_b),
  .drive_a_n  (drive_a_n)
);

// File: tb/sim_bus_xcvr_bank.sv
module sim_bus_xcvr_bank;

  localparam int L = 4;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [L*W-1:0] a_in = '0, b_in = '0;
  logic [L*W-1:0] a_out, b_out;
  logic [L-1:0]   a_oe, b_oe;
  logic [L-1:0]   a_load = '0, b_load = '0, a2b_stored = '0, b2a_stored = '0;
  logic [L-1:0]   drive_b = '0, drive_a_n = '1;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  bus_xcvr_bank #(.LANES(L), .LANE_W(W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .a_load(a_load), .b_load(b_load),
    .a2b_stored(a2b_stored), .b2a_stored(b2a_stored),
    .drive_b(drive_b), .drive_a_n(drive_a_n)
  );

  // Row: drive_b, drive_a_n, a2b_stored, b2a_stored, a_load, b_load,
  //      a_in, b_in, expected a_out, expected b_out, check a, check b
  localparam int NV = 18;
  localparam logic [39:0] VEC [NV] = '{
    {1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,8'h3C,8'hA5,8'h00,8'h00,1'b0,1'b0}, // load both (R3 R4)
    {1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,8'h5A,8'hA5,8'h00,8'h5A,1'b0,1'b1}, // R5
    {1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,8'hFF,8'hA5,8'h00,8'h3C,1'b0,1'b1}, // R6
    {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'hFF,8'hC3,8'hC3,8'h00,1'b1,1'b0}, // R7
    {1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'hFF,8'hC3,8'hA5,8'h00,1'b1,1'b0}, // R8 R4
    {1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,8'h11,8'hC3,8'h00,8'h3C,1'b0,1'b1}, // R3 no rise
    {1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,8'h77,8'hC3,8'h00,8'h77,1'b0,1'b1}, // R3 load while B driven
    {1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,8'h88,8'hC3,8'h00,8'h77,1'b0,1'b1}, // R3 level high
    {1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,8'h88,8'hC3,8'h00,8'h77,1'b0,1'b1},
    {1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,8'h00,8'h96,8'h96,8'h00,1'b1,1'b0}, // R9 copy
    {1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00,8'h00,8'h96,1'b0,1'b1}, // R9
    {1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,8'h00,8'h96,8'h00,1'b1,1'b0}, // R9
    {1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,8'hE1,8'h2D,8'h00,8'h00,1'b0,1'b0},
    {1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00,8'hE1,8'hE1,1'b1,1'b1}, // R7 driven B
    {1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,8'h00,8'h2D,8'h2D,1'b1,1'b1}, // R5 driven A
    {1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,8'h00,8'h00,8'h2D,8'hE1,1'b1,1'b1}, // R6 R8
    {1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,8'h00,8'h00,8'hE1,8'hE1,1'b1,1'b1}, // R9 B reg from b_out
    {1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,8'h00,8'h00,8'hE1,8'hE1,1'b1,1'b1}  // R9
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    a_in = 32'h44_33_22_00;
    b_in = 32'hBB_CC_DD_00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state visible through stored selects on every lane
    drive_b = '1; drive_a_n = '0; a2b_stored = '1; b2a_stored = '1;
    #1;
    chk("R1 a_out after reset", a_out, 32'h0);
    chk("R1 b_out after reset", b_out, 32'h0);
    chk("R2 enables all on", {28'h0, a_oe}, 32'hF);
    chk("R2 b enables all on", {28'h0, b_oe}, 32'hF);
    tick;
    drive_b = '0; drive_a_n = '1; a2b_stored = '0; b2a_stored = '0;
    #1;
    chk("R2 isolation a_oe", {28'h0, a_oe}, 32'h0);
    chk("R2 isolation b_oe", {28'h0, b_oe}, 32'h0);
    @(negedge clk);

    // Table walk on lane 0; lanes 1..3 stay isolated
    for (int k = 0; k < NV; k++) begin
      logic [39:0] v;
      v = VEC[k];
      drive_b[0]    = v[39];
      drive_a_n[0]  = v[38];
      a2b_stored[0] = v[37];
      b2a_stored[0] = v[36];
      a_load[0]     = v[35];
      b_load[0]     = v[34];
      a_in[7:0]     = v[33:26];
      b_in[7:0]     = v[25:18];
      tick;
      chk($sformatf("R2 row %0d a_oe", k), {31'h0, a_oe[0]}, {31'h0, ~v[38]});
      chk($sformatf("R2 row %0d b_oe", k), {31'h0, b_oe[0]}, {31'h0, v[39]});
      chk($sformatf("R11 row %0d other oe", k), {26'h0, a_oe[3:1], b_oe[3:1]}, 32'h0);
      if (v[1]) chk($sformatf("R7/R8/R9 row %0d a_out", k), {24'h0, a_out[7:0]}, {24'h0, v[17:10]});
      if (v[0]) chk($sformatf("R5/R6/R9 row %0d b_out", k), {24'h0, b_out[7:0]}, {24'h0, v[9:2]});
    end
    a_load = '0; b_load = '0;
    tick;

    // R11: lanes 1..3 registers untouched by lane 0 activity
    drive_b = 4'b1110; drive_a_n = 4'b0001; a2b_stored = 4'b1110; b2a_stored = 4'b1110;
    #1;
    chk("R11 lanes 1-3 b_out zero", {8'h0, b_out[31:8]}, 32'h0);
    chk("R11 lanes 1-3 a_out zero", {8'h0, a_out[31:8]}, 32'h0);
    @(negedge clk);

    // R11: load lane 2 only
    drive_b = '0; drive_a_n = '1; a2b_stored = '0; b2a_stored = '0;
    a_in = 32'h99_5E_66_00;
    a_load = 4'b0100;
    tick;
    a_load = '0;
    drive_b = '1; a2b_stored = '1;
    #1;
    chk("R11 lane 2 loaded", {24'h0, b_out[23:16]}, 32'h5E);
    chk("R11 lanes 1 and 3 unchanged", {16'h0, b_out[31:24], b_out[15:8]}, 32'h0);
    chk("R11 lane 0 keeps E1", {24'h0, b_out[7:0]}, 32'hE1);
    @(negedge clk);

    // R10: keeper on lane 3 entered straight from isolation
    drive_b = '0; drive_a_n = '1; a2b_stored = '0; b2a_stored = '0;
    a_in[31:24] = 8'h4B; b_in[31:24] = 8'hB4;
    tick;
    drive_b[3] = 1'b1; drive_a_n[3] = 1'b0;
    #1;
    chk("R10 keeper a_out", {24'h0, a_out[31:24]}, 32'h4B);
    chk("R10 keeper b_out", {24'h0, b_out[31:24]}, 32'hB4);
    @(negedge clk);
    a_in[31:24] = 8'h00; b_in[31:24] = 8'hFF;
    tick;
    tick;
    chk("R10 keeper holds a", {24'h0, a_out[31:24]}, 32'h4B);
    chk("R10 keeper holds b", {24'h0, b_out[31:24]}, 32'hB4);
    chk("R11 lane 2 unaffected by keeper", {31'h0, a_oe[2]}, 32'h0);

    // R10: leave, new value, re-enter
    drive_b[3] = 1'b0; drive_a_n[3] = 1'b1;
    a_in[31:24] = 8'h12; b_in[31:24] = 8'h34;
    tick;
    drive_b[3] = 1'b1; drive_a_n[3] = 1'b0;
    a_in[31:24] = 8'hEE; b_in[31:24] = 8'hDD;
    #1;
    chk("R10 re-entry a_out", {24'h0, a_out[31:24]}, 32'h12);
    chk("R10 re-entry b_out", {24'h0, b_out[31:24]}, 32'h34);
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule